// File: doc/BRIEF.md
# Tap Step Profile Generator

This block schedules the adaptation step size for an adaptive FIR echo-cancelling filter. The coefficient-update engine visits the taps in order, one at a time. For each tap the block supplies the LMS step size as a right-shift exponent `e`, so the step equals 2^-e.

The schedule has three regions:

- **Flat-delay floor.** The first part of the sweep uses the smallest step, exponent 16.
- **Plateau.** A middle stretch uses the full step, exponent 0.
- **Decay.** A tail region makes the step smaller in powers of two. Its period and length come from two small codes.

Shaping the step this way lets the adaptive filter concentrate adaptation where the echo energy is expected.

Software places the profile codes and a length mode on the configuration inputs. The coefficient engine then pulses `sweep_start` and strobes `tap_adv` once per tap. The exponent for the current tap is available combinationally in the same cycle as the strobe. The configuration is captured at the start pulse. A flat-delay code that is too large for the selected length is clamped, and it raises a sticky error flag.

Top module: `tap_step_profile`

## Requirements
- R1: After reset, `sweep_busy`, `step_valid` and `cfg_err` are 0 and `tap_idx` is 0, and `tap_adv` strobes produce no `step_valid`.
- R2: A `sweep_start` pulse captures the configuration inputs, sets `tap_idx` to 0 and sets `sweep_busy` in the next cycle. A `tap_adv` in the same cycle as `sweep_start` is ignored, so `step_valid` stays 0.
- R3: While busy, each `tap_adv` cycle without `sweep_start` raises `step_valid` in that same cycle, with `step_exp` for the tap shown on `tap_idx`. The index then rises by one. Cycles without a strobe leave the index unchanged.
- R4: The sweep length L is 512 taps when `cfg_ext`=0 and 1024 taps when `cfg_ext`=1. After tap L-1 is strobed, `sweep_busy` drops and `tap_idx` reads L. Further strobes give no `step_valid` and do not move the index until the next start.
- R5: Taps below 8 times the captured `cfg_flat` value get exponent 16. This region takes priority over every other region.
- R6: Taps between the end of the flat region and the decay start get exponent 0.
- R7: Decay starts at tap L - NS*SS, where NS is `cfg_nsteps` and SS = 4*2^`cfg_ssc`. When that value is negative, decay starts at tap 0. For example, NS=4 and SSC=4 in normal mode give a start of 256.
- R8: For a tap t at or beyond the decay start D, the exponent is floor((t-D)/SS), saturating at 16.
- R9: The largest legal `cfg_flat` is 64 in normal mode and 128 in extended mode. A larger value is clamped to that maximum when captured, and `cfg_err` goes to 1 and stays 1 until reset.
- R10: Changes to the configuration inputs after a start have no effect on the running sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_flat | input | 8 | Flat-delay length in units of 8 taps |
| cfg_ssc | input | 3 | Decay period code, SS = 4*2^code taps |
| cfg_nsteps | input | 8 | Number of decay periods |
| cfg_ext | input | 1 | 1 selects the 1024-tap length, 0 selects 512 |
| sweep_start | input | 1 | Start pulse: capture config, restart at tap 0 |
| tap_adv | input | 1 | Per-tap advance strobe |
| step_valid | output | 1 | Exponent valid for the tap on `tap_idx` |
| step_exp | output | 5 | Step-size exponent, step = 2^-exp |
| tap_idx | output | 11 | Current tap index |
| sweep_busy | output | 1 | A sweep is in progress |
| cfg_err | output | 1 | Sticky flag: flat-delay code was clamped |

## Verification
The assertions check the sequencing rules on every cycle:

- a start clears the index;
- each accepted strobe steps the index by exactly one, and the index holds without a strobe;
- no valid output appears while idle;
- the exponent never exceeds 16;
- the error flag is sticky.

The shape of the profile can only be shown by the bench's sweeps. This covers the flat floor, the plateau, where the decay starts, the per-period exponent steps and their saturation. The bench also covers clamping of an illegal flat-delay code and immunity to configuration changes during a sweep. It compares every tap of every sweep against a reference model.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int unsigned NORM_TAPS   = 512;
  localparam int unsigned EXT_TAPS    = 2 * NORM_TAPS;
  localparam int unsigned FLAT_SH     = 3;
  localparam int unsigned SS_SH       = 2;
  localparam int unsigned EXP_MAX     = 16;
  localparam int unsigned FD_W        = 8;
  localparam int unsigned SSC_W       = 3;
  localparam int unsigned NS_W        = 8;
  localparam int unsigned SSC_RST     = 4;
  localparam int unsigned TAP_W       = $clog2(EXT_TAPS) + 1;
  localparam int unsigned EXP_W       = $clog2(EXP_MAX + 1);
  localparam int unsigned SH_W        = 4;
  localparam int unsigned PER_W       = SS_SH + (1 << SSC_W) - 1;
  localparam int unsigned PROD_W      = NS_W + PER_W;
  localparam int unsigned FD_MAX_NORM = NORM_TAPS >> FLAT_SH;
  localparam int unsigned FD_MAX_EXT  = EXT_TAPS >> FLAT_SH;

  typedef struct packed {
    logic [FD_W-1:0]  flat;
    logic [SSC_W-1:0] ssc;
    logic [NS_W-1:0]  nsteps;
    logic             ext;
  } prof_cfg_t;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_t;
endpackage

// File: rtl/tsp_cfg_latch.sv
module tsp_cfg_latch
  import tsp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cap,
  input  prof_cfg_t cfg_in,
  output prof_cfg_t cfg_q,
  output logic      err_q
);
  localparam logic [FD_W-1:0] LIM_NORM = FD_W'(FD_MAX_NORM);
  localparam logic [FD_W-1:0] LIM_EXT  = FD_W'(FD_MAX_EXT);

  logic [FD_W-1:0] fd_lim;
  logic            fd_over;
  prof_cfg_t       cfg_d;
  logic            err_d;
  logic            cfg_en;

  always_comb begin
    fd_lim  = cfg_in.ext ? LIM_EXT : LIM_NORM;
    fd_over = (cfg_in.flat > fd_lim);
    cfg_en  = cap;
    cfg_d   = cfg_in;
    if (fd_over) begin
      cfg_d.flat = fd_lim;
    end
    err_d   = err_q | fd_over;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.flat   <= '0;
      cfg_q.ssc    <= SSC_W'(SSC_RST);
      cfg_q.nsteps <= '0;
      cfg_q.ext    <= 1'b0;
      err_q        <= 1'b0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/tsp_region_calc.sv
module tsp_region_calc
  import tsp_pkg::*;
(
  input  prof_cfg_t         cfg,
  output logic [TAP_W-1:0]  flat_end,
  output logic [TAP_W-1:0]  dec_start,
  output logic [TAP_W-1:0]  tap_last,
  output logic [PER_W-1:0]  ss_last
);
  logic [TAP_W-1:0]  len;
  logic [SH_W-1:0]   sh;
  logic [PROD_W-1:0] prod;

  always_comb begin
    len      = cfg.ext ? TAP_W'(EXT_TAPS) : TAP_W'(NORM_TAPS);
    tap_last = len - TAP_W'(1);
    sh       = SH_W'(SS_SH) + SH_W'(cfg.ssc);
    ss_last  = ~({PER_W{1'b1}} << sh);
    prod     = PROD_W'(cfg.nsteps) << sh;
    if (prod >= PROD_W'(len)) begin
      dec_start = '0;
    end else begin
      dec_start = len - prod[TAP_W-1:0];
    end
    flat_end = TAP_W'(cfg.flat) << FLAT_SH;
  end
endmodule

// File: rtl/tsp_tap_seq.sv
module tsp_tap_seq
  import tsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             adv,
  input  logic [TAP_W-1:0] tap_last,
  output logic [TAP_W-1:0] tap_q,
  output logic             busy,
  output logic             fire
);
  seq_state_t       state_q, state_d;
  logic [TAP_W-1:0] tap_d;
  logic             seq_en;

  always_comb begin
    busy    = (state_q == SEQ_RUN);
    fire    = adv & busy & ~start;
    seq_en  = start | fire;
    state_d = state_q;
    tap_d   = tap_q;
    if (start) begin
      state_d = SEQ_RUN;
      tap_d   = '0;
    end else if (fire) begin
      tap_d = tap_q + TAP_W'(1);
      if (tap_q == tap_last) begin
        state_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      tap_q   <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      tap_q   <= tap_d;
    end
  end
endmodule

// File: rtl/tsp_decay_cnt.sv
module tsp_decay_cnt
  import tsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             in_decay,
  input  logic [PER_W-1:0] ss_last,
  output logic [EXP_W-1:0] dexp_q
);
  localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(EXP_MAX);

  logic [PER_W-1:0] per_q, per_d;
  logic [EXP_W-1:0] dexp_d;
  logic             cnt_en;
  logic             period_end;
  logic             at_top;

  always_comb begin
    cnt_en     = clr | (step & in_decay);
    period_end = (per_q == ss_last);
    at_top     = (dexp_q == EXP_TOP);
    per_d      = per_q;
    dexp_d     = dexp_q;
    if (clr) begin
      per_d  = '0;
      dexp_d = '0;
    end else if (period_end) begin
      per_d = '0;
      if (!at_top) begin
        dexp_d = dexp_q + EXP_W'(1);
      end
    end else begin
      per_d = per_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      dexp_q <= '0;
    end else if (cnt_en) begin
      per_q  <= per_d;
      dexp_q <= dexp_d;
    end
  end
endmodule

// File: rtl/tap_step_profile.sv
module tap_step_profile
  import tsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FD_W-1:0]  cfg_flat,
  input  logic [SSC_W-1:0] cfg_ssc,
  input  logic [NS_W-1:0]  cfg_nsteps,
  input  logic             cfg_ext,
  input  logic             sweep_start,
  input  logic             tap_adv,
  output logic             step_valid,
  output logic [EXP_W-1:0] step_exp,
  output logic [TAP_W-1:0] tap_idx,
  output logic             sweep_busy,
  output logic             cfg_err
);
  prof_cfg_t        cfg_raw;
  prof_cfg_t        cfg_q;
  logic [TAP_W-1:0] flat_end;
  logic [TAP_W-1:0] dec_start;
  logic [TAP_W-1:0] tap_last;
  logic [PER_W-1:0] ss_last;
  logic [EXP_W-1:0] dexp;
  logic             fire;
  logic             in_flat;
  logic             in_decay;

  always_comb begin
    cfg_raw.flat   = cfg_flat;
    cfg_raw.ssc    = cfg_ssc;
    cfg_raw.nsteps = cfg_nsteps;
    cfg_raw.ext    = cfg_ext;
  end

  tsp_cfg_latch u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (sweep_start),
    .cfg_in (cfg_raw),
    .cfg_q  (cfg_q),
    .err_q  (cfg_err)
  );

  tsp_region_calc u_region (
    .cfg       (cfg_q),
    .flat_end  (flat_end),
    .dec_start (dec_start),
    .tap_last  (tap_last),
    .ss_last   (ss_last)
  );

  tsp_tap_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (sweep_start),
    .adv      (tap_adv),
    .tap_last (tap_last),
    .tap_q    (tap_idx),
    .busy     (sweep_busy),
    .fire     (fire)
  );

  tsp_decay_cnt u_decay (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sweep_start),
    .step     (fire),
    .in_decay (in_decay),
    .ss_last  (ss_last),
    .dexp_q   (dexp)
  );

  // Region priority: flat floor, then decay, else full step.
  always_comb begin
    in_flat    = (tap_idx < flat_end);
    in_decay   = (tap_idx >= dec_start);
    step_valid = fire;
    if (in_flat) begin
      step_exp = EXP_W'(EXP_MAX);
    end else if (in_decay) begin
      step_exp = dexp;
    end else begin
      step_exp = '0;
    end
  end
endmodule

// File: rtl/tsp_checker.sv
module tsp_checker
  import tsp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sweep_start,
  input logic             tap_adv,
  input logic             step_valid,
  input logic [EXP_W-1:0] step_exp,
  input logic [TAP_W-1:0] tap_idx,
  input logic             sweep_busy,
  input logic             cfg_err
);
  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_start |=> (tap_idx == '0) && sweep_busy);

  p_start_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_start |-> !step_valid);

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |=> tap_idx == $past(tap_idx) + TAP_W'(1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tap_adv && !sweep_start) |=> $stable(tap_idx));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_busy |-> !step_valid);

  p_exp_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> step_exp <= EXP_W'(EXP_MAX));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind tap_step_profile tsp_checker u_tsp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sweep_start (sweep_start),
  .tap_adv     (tap_adv),
  .step_valid  (step_valid),
  .step_exp    (step_exp),
  .tap_idx     (tap_idx),
  .sweep_busy  (sweep_busy),
  .cfg_err     (cfg_err)
);

// File: tb/tap_step_profile_bench.sv
module tap_step_profile_bench;
  logic        clk;
  logic        rst_n;
  logic [7:0]  cfg_flat;
  logic [2:0]  cfg_ssc;
  logic [7:0]  cfg_nsteps;
  logic        cfg_ext;
  logic        sweep_start;
  logic        tap_adv;
  logic        step_valid;
  logic [4:0]  step_exp;
  logic [10:0] tap_idx;
  logic        sweep_busy;
  logic        cfg_err;

  int n_checks;
  int n_errors;
  int cur_tap;
  int l_fd, l_ssc, l_ns;
  bit l_ext;
  bit exp_err;
  bit done;

  tap_step_profile u_tap_step_profile (
    .clk(clk), .rst_n(rst_n), .cfg_flat(cfg_flat), .cfg_ssc(cfg_ssc),
    .cfg_nsteps(cfg_nsteps), .cfg_ext(cfg_ext), .sweep_start(sweep_start),
    .tap_adv(tap_adv), .step_valid(step_valid), .step_exp(step_exp),
    .tap_idx(tap_idx), .sweep_busy(sweep_busy), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int exp_ref(int t, int fd, int ssc, int ns, bit ext);
    int len  = ext ? 1024 : 512;
    int fmax = ext ? 128 : 64;
    int f    = (fd > fmax) ? fmax : fd;
    int ss   = 4 << ssc;
    int prod = ns * ss;
    int ds   = (prod >= len) ? 0 : len - prod;
    int e;
    if (t < f * 8) return 16;
    if (t < ds) return 0;
    e = (t - ds) / ss;
    return (e > 16) ? 16 : e;
  endfunction

  task automatic chk(string req, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d (tap %0d)", req, act, expv, cur_tap);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  task automatic start_sweep(int fd, int ssc, int ns, bit ext, bit scramble);
    @(negedge clk);
    cfg_flat = 8'(fd); cfg_ssc = 3'(ssc); cfg_nsteps = 8'(ns); cfg_ext = ext;
    sweep_start = 1'b1; tap_adv = 1'b0;
    l_fd = fd; l_ssc = ssc; l_ns = ns; l_ext = ext;
    if (fd > (ext ? 128 : 64)) exp_err = 1'b1;
    @(negedge clk);
    sweep_start = 1'b0;
    cur_tap = 0;
    chk("R2 index cleared", int'(tap_idx), 0);
    chk("R2 busy set", int'(sweep_busy), 1);
    chk("R9 error flag", int'(cfg_err), int'(exp_err));
    if (scramble) begin
      // R10: inputs change under a running sweep
      cfg_flat = 8'($urandom); cfg_ssc = 3'($urandom);
      cfg_nsteps = 8'($urandom); cfg_ext = 1'($urandom);
    end
  endtask

  task automatic step_taps(int n, int gap_pct);
    for (int i = 0; i < n; i++) begin
      while (int'($urandom_range(99, 0)) < gap_pct) begin
        tap_adv = 1'b0;
        @(negedge clk);
        chk("R3 hold without strobe", int'(tap_idx), cur_tap);
      end
      tap_adv = 1'b1;
      #1;
      chk("R3 valid with strobe", int'(step_valid), 1);
      chk("R3 index", int'(tap_idx), cur_tap);
      chk("R5-R8 exponent", int'(step_exp), exp_ref(cur_tap, l_fd, l_ssc, l_ns, l_ext));
      @(negedge clk);
      tap_adv = 1'b0;
      cur_tap++;
    end
  endtask

  task automatic finish_sweep(int gap_pct);
    int len = l_ext ? 1024 : 512;
    step_taps(len - cur_tap, gap_pct);
    chk("R4 busy drops", int'(sweep_busy), 0);
    chk("R4 index at length", int'(tap_idx), len);
    tap_adv = 1'b1;
    #1;
    chk("R4 strobe after end ignored", int'(step_valid), 0);
    @(negedge clk);
    tap_adv = 1'b0;
    chk("R4 index unchanged", int'(tap_idx), len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_checks = 0; n_errors = 0; done = 1'b0; exp_err = 1'b0; cur_tap = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_flat = '0; cfg_ssc = '0; cfg_nsteps = '0; cfg_ext = 1'b0;
    sweep_start = 1'b0; tap_adv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, strobe while idle
    tap_adv = 1'b1;
    #1;
    chk("R1 busy", int'(sweep_busy), 0);
    chk("R1 valid", int'(step_valid), 0);
    chk("R1 index", int'(tap_idx), 0);
    chk("R1 error", int'(cfg_err), 0);
    @(negedge clk);
    tap_adv = 1'b0;
    chk("R1 index after idle strobe", int'(tap_idx), 0);

    // R7: NS=4, SSC=4, normal: decay from tap 256, exponent 1 from tap 320
    start_sweep(0, 4, 4, 1'b0, 1'b0);
    step_taps(256, 0);
    chk("R7 decay start tap 256", exp_ref(256, 0, 4, 4, 1'b0), 0);
    chk("R7 first halving at 320", exp_ref(320, 0, 4, 4, 1'b0), 1);
    finish_sweep(0);

    // R5, R6: flat floor of 40 taps then plateau
    start_sweep(5, 4, 4, 1'b0, 1'b1);
    finish_sweep(10);

    // R8 saturation, R9 legal extended maximum, R4 extended length
    start_sweep(128, 0, 255, 1'b1, 1'b0);
    finish_sweep(0);
    start_sweep(2, 0, 255, 1'b1, 1'b1);
    finish_sweep(0);

    // R7 negative start clamped to 0
    start_sweep(0, 2, 200, 1'b0, 1'b0);
    finish_sweep(5);

    // R5 priority over decay everywhere
    start_sweep(64, 1, 255, 1'b0, 1'b0);
    finish_sweep(0);

    // R2: restart mid-sweep with a simultaneous strobe
    start_sweep(3, 3, 10, 1'b0, 1'b0);
    step_taps(100, 0);
    @(negedge clk);
    cfg_flat = 8'd1; cfg_ssc = 3'd5; cfg_nsteps = 8'd3; cfg_ext = 1'b0;
    sweep_start = 1'b1; tap_adv = 1'b1;
    l_fd = 1; l_ssc = 5; l_ns = 3; l_ext = 1'b0;
    #1;
    chk("R2 strobe with start ignored", int'(step_valid), 0);
    @(negedge clk);
    sweep_start = 1'b0; tap_adv = 1'b0; cur_tap = 0;
    chk("R2 restart index", int'(tap_idx), 0);
    finish_sweep(0);

    // R9: illegal flat code clamped, flag sticky
    chk("R9 flag clear before illegal code", int'(cfg_err), 0);
    start_sweep(100, 4, 4, 1'b0, 1'b0);
    finish_sweep(0);
    start_sweep(7, 4, 4, 1'b0, 1'b0);
    chk("R9 flag sticky", int'(cfg_err), 1);
    finish_sweep(0);

    // Random sweeps with gaps and scrambled inputs (R3, R5-R8, R10)
    for (int k = 0; k < 8; k++) begin
      start_sweep(int'($urandom_range(140, 0)), int'($urandom_range(7, 0)),
                  int'($urandom_range(255, 0)), 1'($urandom), 1'b1);
      finish_sweep(20);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule